// File: doc/BRIEF.md
# Speculative Access Conflict Monitor

While a core runs a critical section with its lock elided, this block records every cache line the core touches. A line the core loads gets a read mark and a line it stores gets a write mark. Each incoming coherence snoop is compared with those marks. When a snoop shows that the section can no longer appear atomic, the block aborts the speculation with a reason code, and the core's recovery logic then rolls back and re-executes the section.

The rules differ by mark. A line that was only read tolerates remote readers but not a remote exclusive or invalidating request. A line that was written tolerates no remote access of any kind. The lock variable is treated like any other line. Reading it is fine, and a later remote write to it ends the speculation. The tracker has a fixed number of fully associative entries. A region that touches more distinct lines than that aborts with a capacity reason. Commit and external abort clear all marks in a single cycle and return the block to idle.

Top module: `spec_conflict_monitor`

## Requirements
- R1: After reset `busy` and `abort_pulse` are 0. `spec_begin` while idle sets `busy` from the next cycle. While idle, snoops and local accesses have no effect.
- R2: An exclusive snoop (`snp_excl`=1) to a line holding only a read mark raises `abort_pulse` with `abort_reason`=2'b01 in the cycle after the snoop.
- R3: A shared snoop (`snp_excl`=0) to a line holding only a read mark causes no abort, and `busy` stays 1.
- R4: Any snoop, shared or exclusive, to a line with a write mark raises `abort_reason`=2'b10. This holds even when the line also carries a read mark.
- R5: Local loads and stores never cause a conflict abort. Snoops to lines that are not tracked have no effect.
- R6: A repeated access to a tracked line reuses its entry and consumes no new capacity.
- R7: A local access that needs more new entries than are free (DEPTH=16 by default) aborts with `abort_reason`=2'b11. A conflict in the same cycle takes priority.
- R8: `spec_commit` or `spec_abort` while busy clears every mark and drops `busy` in the next cycle without an abort pulse. Marks also clear on every conflict or overflow abort.
- R9: A snoop and a local access to the same line in the same cycle are checked against the marks as they stood before that cycle's update.
- R10: `abort_pulse` lasts exactly one cycle, `busy` is 0 in that cycle, and `abort_reason` is 2'b00 whenever no pulse is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spec_begin | input | 1 | Start a speculative region |
| spec_commit | input | 1 | End the region successfully |
| spec_abort | input | 1 | End the region on an external request |
| ld_valid | input | 1 | Local load strobe |
| ld_line | input | LINE_W | Local load line address |
| st_valid | input | 1 | Local store strobe |
| st_line | input | LINE_W | Local store line address |
| snp_valid | input | 1 | Snoop strobe |
| snp_line | input | LINE_W | Snoop line address |
| snp_excl | input | 1 | 1 = exclusive/invalidate request, 0 = shared read |
| abort_pulse | output | 1 | One-cycle misspeculation indication |
| abort_reason | output | 2 | 01 read-line conflict, 10 written-line conflict, 11 overflow |
| busy | output | 1 | Speculative region in progress |

## Verification
All three outputs are registered once. A stimulus applied in cycle k is sampled at one rising edge, and its effect on `abort_pulse`, `abort_reason` and `busy` is visible during cycle k+1. Marks written at that edge first affect snoops in cycle k+1. The driver applies one set of inputs per cycle just after the falling edge and pushes one expected output triple for that cycle. The monitor compares at the next falling edge, a full cycle of register delay later and away from the active edge. Each expectation is therefore matched exactly one register stage after its stimulus, and a pulse that lasts too long is caught by the expectation for the following cycle.

// File: rtl/scm_pkg.sv
// Shared types for the speculative access conflict monitor.
// Assumes: reason codes are decoded by the recovery logic outside this block.
package scm_pkg;

    typedef enum logic [1:0] {
        RSN_NONE = 2'b00,
        RSN_RD   = 2'b01,
        RSN_WR   = 2'b10,
        RSN_OVF  = 2'b11
    } reason_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } mode_t;

endpackage

// File: rtl/scm_line_table.sv
// Fully associative line table with a read mark and a write mark per entry.
// Provides hit vectors for local accesses, OR-reduced read/write hits for the
// snoop address, and the free-entry vector. All outputs reflect the state
// held before the current clock edge.
// Assumes: at most one entry matches any address (the allocator guarantees it).
module scm_line_table #(
    parameter int DEPTH  = 16,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] ld_line,
    input  logic [LINE_W-1:0] st_line,
    input  logic [LINE_W-1:0] snp_line,
    input  logic [DEPTH-1:0]  ld_sel,
    input  logic [DEPTH-1:0]  st_sel,
    output logic [DEPTH-1:0]  ld_hit,
    output logic [DEPTH-1:0]  st_hit,
    output logic              snp_hit_rd,
    output logic              snp_hit_wr,
    output logic [DEPTH-1:0]  free_vec
);

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] rmark;
    logic [DEPTH-1:0] wmark;
    logic [DEPTH-1:0] snp_rd_vec;
    logic [DEPTH-1:0] snp_wr_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [LINE_W-1:0] tag;

        // Entry storage: flash clear, otherwise set marks on selection.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                vld[g]   <= 1'b0;
                rmark[g] <= 1'b0;
                wmark[g] <= 1'b0;
                tag      <= '0;
            end else if (upd_en) begin
                if (ld_sel[g]) begin
                    vld[g]   <= 1'b1;
                    rmark[g] <= 1'b1;
                    tag      <= ld_line;
                end
                if (st_sel[g]) begin
                    vld[g]   <= 1'b1;
                    wmark[g] <= 1'b1;
                    tag      <= st_line;
                end
            end
        end

        // Per-entry address compare against the three request ports.
        always_comb begin
            ld_hit[g]     = vld[g] && (tag == ld_line);
            st_hit[g]     = vld[g] && (tag == st_line);
            snp_rd_vec[g] = vld[g] && rmark[g] && (tag == snp_line);
            snp_wr_vec[g] = vld[g] && wmark[g] && (tag == snp_line);
        end
    end

    // Reduce snoop matches and expose the free entries.
    always_comb begin
        snp_hit_rd = |snp_rd_vec;
        snp_hit_wr = |snp_wr_vec;
        free_vec   = ~vld;
    end

    // R6: one line never occupies two entries
    p_hit_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_hit) && $onehot0(st_hit));

    // R8: a clear leaves every entry free
    p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (free_vec == {DEPTH{1'b1}}));

endmodule

// File: rtl/scm_free_pick.sv
// Picks the two lowest-numbered free entries as one-hot vectors and reports
// whether one or two entries are available.
// Assumes: free_vec is a plain bit vector, bit i set when entry i is empty.
module scm_free_pick #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [DEPTH-1:0] first_free,
    output logic [DEPTH-1:0] second_free,
    output logic             have_one,
    output logic             have_two
);

    logic [DEPTH-1:0] rest;

    // Isolate the lowest set bit twice to find two distinct free slots.
    always_comb begin
        first_free  = free_vec & (~free_vec + {{(DEPTH-1){1'b0}}, 1'b1});
        rest        = free_vec & ~first_free;
        second_free = rest & (~rest + {{(DEPTH-1){1'b0}}, 1'b1});
        have_one    = |free_vec;
        have_two    = |rest;
    end

endmodule

// File: rtl/scm_conflict.sv
// Applies the asymmetric snoop rules: a written line conflicts with any snoop,
// and a read line conflicts only with an exclusive request.
// Assumes: hit inputs come from marks held before the current edge.
module scm_conflict
    import scm_pkg::*;
(
    input  logic    snp_valid,
    input  logic    snp_excl,
    input  logic    hit_rd,
    input  logic    hit_wr,
    output logic    conflict,
    output reason_t reason
);

    // Written-line conflicts outrank read-line conflicts.
    always_comb begin
        reason = RSN_NONE;
        if (snp_valid && hit_wr) begin
            reason = RSN_WR;
        end else if (snp_valid && snp_excl && hit_rd) begin
            reason = RSN_RD;
        end
        conflict = (reason != RSN_NONE);
    end

endmodule

// File: rtl/spec_conflict_monitor.sv
// Top of the speculative access conflict monitor. Runs the idle/active mode,
// steers local accesses to existing or newly allocated entries, detects
// overflow, and registers the abort pulse with its reason.
// Assumes: control strobes are single-cycle and come from the core; the
// snoop stream comes from the coherence engine; recovery happens elsewhere.
module spec_conflict_monitor
    import scm_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_begin,
    input  logic              spec_commit,
    input  logic              spec_abort,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    input  logic              st_valid,
    input  logic [LINE_W-1:0] st_line,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              snp_excl,
    output logic              abort_pulse,
    output logic [1:0]        abort_reason,
    output logic              busy
);

    mode_t            mode;
    reason_t          reason_q;
    logic [DEPTH-1:0] ld_hit, st_hit, free_vec;
    logic [DEPTH-1:0] first_free, second_free;
    logic [DEPTH-1:0] ld_sel, st_sel;
    logic             have_one, have_two;
    logic             snp_hit_rd, snp_hit_wr;
    logic             conflict;
    reason_t          conf_reason;
    logic             active, same_line, ld_new, st_new, overflow;
    logic             clear, upd_en;

    scm_line_table #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .upd_en     (upd_en),
        .ld_line    (ld_line),
        .st_line    (st_line),
        .snp_line   (snp_line),
        .ld_sel     (ld_sel),
        .st_sel     (st_sel),
        .ld_hit     (ld_hit),
        .st_hit     (st_hit),
        .snp_hit_rd (snp_hit_rd),
        .snp_hit_wr (snp_hit_wr),
        .free_vec   (free_vec)
    );

    scm_free_pick #(.DEPTH(DEPTH)) u_pick (
        .free_vec    (free_vec),
        .first_free  (first_free),
        .second_free (second_free),
        .have_one    (have_one),
        .have_two    (have_two)
    );

    scm_conflict u_conf (
        .snp_valid (snp_valid && active),
        .snp_excl  (snp_excl),
        .hit_rd    (snp_hit_rd),
        .hit_wr    (snp_hit_wr),
        .conflict  (conflict),
        .reason    (conf_reason)
    );

    // Classify local accesses and choose the entry each one updates.
    always_comb begin
        active    = (mode == ST_ACTIVE);
        same_line = ld_valid && st_valid && (ld_line == st_line);
        ld_new    = ld_valid && !(|ld_hit);
        st_new    = st_valid && !(|st_hit) && !same_line;
        overflow  = active && (((ld_new || st_new) && !have_one) ||
                               (ld_new && st_new && !have_two));

        ld_sel = '0;
        if (ld_valid) begin
            ld_sel = (|ld_hit) ? ld_hit : first_free;
        end

        st_sel = '0;
        if (st_valid) begin
            if (same_line) begin
                st_sel = (|ld_hit) ? ld_hit : first_free;
            end else if (|st_hit) begin
                st_sel = st_hit;
            end else begin
                st_sel = ld_new ? second_free : first_free;
            end
        end

        clear  = active && (conflict || overflow || spec_commit || spec_abort);
        upd_en = active && !clear;
    end

    // Mode sequencing and registered abort reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode        <= ST_IDLE;
            abort_pulse <= 1'b0;
            reason_q    <= RSN_NONE;
        end else begin
            abort_pulse <= 1'b0;
            reason_q    <= RSN_NONE;
            if (!active) begin
                if (spec_begin) begin
                    mode <= ST_ACTIVE;
                end
            end else if (conflict) begin
                mode        <= ST_IDLE;
                abort_pulse <= 1'b1;
                reason_q    <= conf_reason;
            end else if (overflow) begin
                mode        <= ST_IDLE;
                abort_pulse <= 1'b1;
                reason_q    <= RSN_OVF;
            end else if (spec_commit || spec_abort) begin
                mode <= ST_IDLE;
            end
        end
    end

    // Drive the output ports from state.
    always_comb begin
        busy         = (mode == ST_ACTIVE);
        abort_reason = reason_q;
    end

    // R10: pulse is a single cycle and the block is idle while it shows
    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);
    p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!busy && abort_reason != 2'b00));

    // R1: an abort can only follow a busy cycle
    p_abort_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(busy));

    // R5: conflict reasons need a snoop in the previous cycle
    p_conflict_from_snoop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && (abort_reason == 2'b01 || abort_reason == 2'b10))
            |-> $past(snp_valid));

    // R7: overflow only when fewer than two entries were free
    p_overflow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && abort_reason == 2'b11) |-> $past(!have_two));

    // R8: commit drops busy with no pulse when nothing conflicts
    p_commit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && spec_commit && !snp_valid && !ld_valid && !st_valid)
            |=> (!busy && !abort_pulse));

endmodule

// File: tb/tb_spec_conflict_monitor.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues the
// expected outputs; the monitor checks them at the next falling edge.
module tb_spec_conflict_monitor;

    localparam int W = 26;

    typedef struct {
        logic       ab;
        logic [1:0] rs;
        logic       bz;
        string      req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         spec_begin = 0, spec_commit = 0, spec_abort = 0;
    logic         ld_valid = 0, st_valid = 0, snp_valid = 0, snp_excl = 0;
    logic [W-1:0] ld_line = '0, st_line = '0, snp_line = '0;
    logic         abort_pulse, busy;
    logic [1:0]   abort_reason;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    spec_conflict_monitor #(.DEPTH(16), .LINE_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .spec_begin(spec_begin), .spec_commit(spec_commit), .spec_abort(spec_abort),
        .ld_valid(ld_valid), .ld_line(ld_line),
        .st_valid(st_valid), .st_line(st_line),
        .snp_valid(snp_valid), .snp_line(snp_line), .snp_excl(snp_excl),
        .abort_pulse(abort_pulse), .abort_reason(abort_reason), .busy(busy)
    );

    // Monitor: compare the oldest expectation one cycle after its stimulus.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (abort_pulse !== e.ab || abort_reason !== e.rs || busy !== e.bz) begin
                errors++;
                $display("FAIL %s: got ab=%0b rs=%0b busy=%0b, expected ab=%0b rs=%0b busy=%0b",
                         e.req, abort_pulse, abort_reason, busy, e.ab, e.rs, e.bz);
            end
        end
    end

    // Driver: apply one cycle of inputs and queue the outputs due next cycle.
    task automatic step(input bit b, c, a,
                        input bit lv, input logic [W-1:0] la,
                        input bit sv, input logic [W-1:0] sa,
                        input bit nv, input logic [W-1:0] na, input bit nx,
                        input bit eab, input logic [1:0] ers, input bit ebz,
                        input string req);
        exp_t e;
        @(negedge clk);
        #1;
        spec_begin = b; spec_commit = c; spec_abort = a;
        ld_valid = lv; ld_line = la;
        st_valid = sv; st_line = sa;
        snp_valid = nv; snp_line = na; snp_excl = nx;
        e.ab = eab; e.rs = ers; e.bz = ebz; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle_step(input bit ebz, input string req);
        step(0,0,0, 0,0, 0,0, 0,0,0, 0,2'b00,ebz, req);
    endtask

    task automatic begin_step(input string req);
        step(1,0,0, 0,0, 0,0, 0,0,0, 0,2'b00,1, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || abort_pulse !== 1'b0 || abort_reason !== 2'b00) begin
            errors++;
            $display("FAIL R1 reset: got busy=%0b ab=%0b rs=%0b, expected 0 0 00",
                     busy, abort_pulse, abort_reason);
        end
        rst_n = 1'b1;

        // R1: idle ignores snoops and local accesses
        step(0,0,0, 1,'h5, 1,'h5, 1,'h5,1, 0,2'b00,0, "R1 idle ignores traffic");
        begin_step("R1 begin sets busy");

        // R3 / R5 / R2: read line rules, lock read then remote write
        step(0,0,0, 1,'h10, 0,0, 0,0,0, 0,2'b00,1, "R5 local load");
        step(0,0,0, 0,0, 0,0, 1,'h10,0, 0,2'b00,1, "R3 shared snoop on read line");
        step(0,0,0, 0,0, 0,0, 1,'h99,1, 0,2'b00,1, "R5 snoop to untracked line");
        step(0,0,0, 0,0, 1,'h20, 0,0,0, 0,2'b00,1, "R5 local store");
        step(0,0,0, 0,0, 0,0, 1,'h10,1, 1,2'b01,0, "R2 exclusive snoop on read line");
        idle_step(0, "R10 pulse ends after one cycle");

        // R4: written line, shared snoop
        begin_step("R4 begin");
        step(0,0,0, 0,0, 1,'h30, 0,0,0, 0,2'b00,1, "R4 store");
        step(0,0,0, 0,0, 0,0, 1,'h30,0, 1,2'b10,0, "R4 shared snoop on written line");

        // R4: line with both marks, exclusive snoop
        begin_step("R4 begin 2");
        step(0,0,0, 1,'h40, 1,'h40, 0,0,0, 0,2'b00,1, "R4 load+store same line");
        step(0,0,0, 0,0, 0,0, 1,'h40,1, 1,2'b10,0, "R4 exclusive snoop on read+written line");

        // R9: same-cycle snoop sees the marks before the update
        begin_step("R9 begin");
        step(0,0,0, 0,0, 1,'h50, 1,'h50,0, 0,2'b00,1, "R9 same-cycle snoop and store");
        step(0,0,0, 0,0, 0,0, 1,'h50,0, 1,2'b10,0, "R9 later snoop sees write mark");

        // R8: commit clears, external abort ends quietly
        begin_step("R8 begin");
        step(0,0,0, 0,0, 1,'h60, 0,0,0, 0,2'b00,1, "R8 store");
        step(0,1,0, 0,0, 0,0, 0,0,0, 0,2'b00,0, "R8 commit drops busy");
        begin_step("R8 begin again");
        step(0,0,0, 0,0, 0,0, 1,'h60,1, 0,2'b00,1, "R8 marks cleared by commit");
        step(0,0,1, 0,0, 0,0, 0,0,0, 0,2'b00,0, "R8 external abort no pulse");

        // R6 / R7: fill 16 entries, reuse, then overflow
        begin_step("R7 begin");
        for (int i = 0; i < 16; i++) begin
            step(0,0,0, 1,W'('h100 + i), 0,0, 0,0,0, 0,2'b00,1, "R6 fill distinct lines");
        end
        step(0,0,0, 0,0, 1,'h105, 0,0,0, 0,2'b00,1, "R6 store reuses entry");
        step(0,0,0, 1,'h100, 1,'h10f, 0,0,0, 0,2'b00,1, "R6 repeat accesses no overflow");
        step(0,0,0, 1,'h200, 0,0, 0,0,0, 1,2'b11,0, "R7 17th line overflows");
        idle_step(0, "R10 overflow pulse single cycle");

        // R8: overflow also cleared the marks
        begin_step("R8 begin after overflow");
        step(0,0,0, 0,0, 0,0, 1,'h105,1, 0,2'b00,1, "R8 marks cleared by overflow abort");

        // R7: conflict outranks overflow in the same cycle
        for (int i = 0; i < 15; i++) begin
            step(0,0,0, 1,W'('h300 + i), 0,0, 0,0,0, 0,2'b00,1, "R7 refill");
        end
        step(0,0,0, 0,0, 1,'h400, 0,0,0, 0,2'b00,1, "R7 last free entry by store");
        step(0,0,0, 1,'h500, 0,0, 1,'h400,0, 1,2'b10,0, "R7 conflict beats overflow");
        idle_step(0, "R10 final idle");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule